// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Controller

This block keeps the status byte of a serial flash device and rules on every command that would alter the device. A front end that has already decoded a complete command delivers it as a one-cycle pulse with an operation code, a target address and, for a status write, the new status byte. The block also watches the active-low write-protect pin. One cycle later it answers with exactly one accept or reject pulse. It then updates the write-enable latch, the protect bits and the busy flag.

A modifying operation needs the write-enable latch to be set first. It must also pass the software region lock, which is set by the two protect bits. A status write must also pass the hardware lock, which holds while the status write-disable bit is 1 and the pin is low. An accepted modifying operation holds the busy flag for a cycle count chosen per operation type. When that count runs out, the busy flag and the write-enable latch clear together. The array itself and the nonvolatile copy of the bits lie outside this block.

Top module: `wp_status_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, and neither cmdAccept nor cmdReject is high.
- R2: The status byte is laid out as bit7 write-disable, bit3 and bit2 protect code (bit3 high), bit1 write-enable latch and bit0 busy. Bits 6, 5 and 4 always read 0.
- R3: When idle, write-enable (op 0) is accepted and sets the latch. Write-disable (op 1) is accepted and clears it.
- R4: Status write (op 2), page program (op 3), sector erase (op 4), block erase (op 5) and chip erase (op 6) are rejected while the latch is 0. A rejection changes no status bit.
- R5: While bit7 is 1 and wpN is 0, a status write is rejected even with the latch set.
- R6: An accepted status write copies wrData bits 7, 3 and 2 into the status byte and leaves the other bits alone.
- R7: The block is cmdAddr[17:16]. Program and sector or block erase are rejected on a locked block. Protect code 00 locks none, 01 locks block 3, 10 locks blocks 2 and 3, and 11 locks all.
- R8: Chip erase is accepted only when the protect code is 00.
- R9: An accepted op 2 to 6 raises busy on the cycle of the accept pulse and keeps it high for exactly WRSR_CYC, PP_CYC, SE_CYC, BE_CYC or CE_CYC cycles. In the cycle where busy falls, the latch falls too.
- R10: While busy is 1, every command is rejected and the status byte is untouched except for the busy countdown.
- R11: Each cmdValid pulse produces exactly one one-cycle pulse on cmdAccept or cmdReject, one cycle later. Op 7 is always rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset (power-up) |
| cmdValid | input | 1 | One-cycle pulse marking a completed command |
| cmdOp | input | 3 | Operation code 0..7 |
| cmdAddr | input | 18 | Target byte address |
| wrData | input | 8 | New status byte for a status write |
| wpN | input | 1 | Write-protect pin, active low |
| statusReg | output | 8 | Current status byte |
| cmdAccept | output | 1 | Command accepted pulse |
| cmdReject | output | 1 | Command rejected pulse |

## Verification
The hardest state to reach is the hardware lock with the latch still set. Getting there needs a status write that sets bit7, a full busy period, a fresh write-enable, and then the pin pulled low before the next status write. The stimulus walks through that chain and checks that the rejected write leaves both the latch and the protect code in place. Each protect code is then installed in turn through an accepted status write. Program and erase requests aimed on either side of the locked boundary follow, and a behavioural model checks the busy length cycle by cycle.

// File: rtl/wpctl_pkg.sv
package wpctl_pkg;

  typedef enum logic [2:0] {
    OP_WREN = 3'd0,
    OP_WRDI = 3'd1,
    OP_WRSR = 3'd2,
    OP_PP   = 3'd3,
    OP_SE   = 3'd4,
    OP_BE   = 3'd5,
    OP_CE   = 3'd6,
    OP_RSVD = 3'd7
  } wpOp_e;

  typedef struct packed {
    logic  setWel;
    logic  clrWel;
    logic  wrStatus;
    logic  startBusy;
    wpOp_e kind;
  } wpStrobe_t;

endpackage

// File: rtl/wpctl_ctrl.sv
module wpctl_ctrl
  import wpctl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BLK_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              wpN,
  input  logic              wel,
  input  logic              wip,
  input  logic              srwd,
  input  logic [1:0]        bp,
  output wpStrobe_t         strb,
  output logic              cmdAccept,
  output logic              cmdReject
);

  localparam int NUM_BLK = 1 << BLK_W;

  wpOp_e             op;
  logic [BLK_W-1:0]  blk;
  logic [BLK_W:0]    lockBase;
  logic              hwLock;
  logic              regionLocked;
  logic              grant;

  assign op     = wpOp_e'(cmdOp);
  assign blk    = cmdAddr[ADDR_W-1 -: BLK_W];
  assign hwLock = srwd & ~wpN;

  // lowest locked block: top quarter-ish, top half, all
  always_comb begin
    case (bp)
      2'd1:    lockBase = (BLK_W+1)'(NUM_BLK - 1);
      2'd2:    lockBase = (BLK_W+1)'(NUM_BLK - 2);
      default: lockBase = '0;
    endcase
  end

  always_comb begin
    if (bp == 2'd0)      regionLocked = 1'b0;
    else if (bp == 2'd3) regionLocked = 1'b1;
    else                 regionLocked = ({1'b0, blk} >= lockBase);
  end

  always_comb begin
    grant = 1'b0;
    strb  = '0;
    strb.kind = op;
    if (cmdValid && !wip) begin
      case (op)
        OP_WREN: begin grant = 1'b1; strb.setWel = 1'b1; end
        OP_WRDI: begin grant = 1'b1; strb.clrWel = 1'b1; end
        OP_WRSR: if (wel && !hwLock) begin
          grant = 1'b1; strb.wrStatus = 1'b1; strb.startBusy = 1'b1;
        end
        OP_PP, OP_SE, OP_BE: if (wel && !regionLocked) begin
          grant = 1'b1; strb.startBusy = 1'b1;
        end
        OP_CE: if (wel && bp == 2'd0) begin
          grant = 1'b1; strb.startBusy = 1'b1;
        end
        default: grant = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
    end else begin
      cmdAccept <= cmdValid & grant;
      cmdReject <= cmdValid & ~grant;
    end
  end

  // R11
  accRejExcl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));

  // R5
  hpmReject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd2 && srwd && !wpN) |=> cmdReject);

  // R8
  ceGuard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd6 && bp != 2'd0) |=> cmdReject);

  // R10
  busyReject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && wip) |=> cmdReject);

  // R4
  noWelReject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !wel && cmdOp >= 3'd2 && cmdOp <= 3'd6) |=> cmdReject);

endmodule

// File: rtl/wpctl_dp.sv
module wpctl_dp
  import wpctl_pkg::*;
#(
  parameter int WRSR_CYC = 16,
  parameter int PP_CYC   = 32,
  parameter int SE_CYC   = 64,
  parameter int BE_CYC   = 128,
  parameter int CE_CYC   = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  wpStrobe_t  strb,
  input  logic [7:0] wrData,
  output logic       wel,
  output logic       wip,
  output logic       srwd,
  output logic [1:0] bp,
  output logic [7:0] statusReg
);

  localparam int MAX_A = (WRSR_CYC > PP_CYC) ? WRSR_CYC : PP_CYC;
  localparam int MAX_B = (SE_CYC > BE_CYC) ? SE_CYC : BE_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAXC  = (MAX_C > CE_CYC) ? MAX_C : CE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (strb.kind)
      OP_WRSR: loadVal = CNT_W'(WRSR_CYC - 1);
      OP_PP:   loadVal = CNT_W'(PP_CYC - 1);
      OP_SE:   loadVal = CNT_W'(SE_CYC - 1);
      OP_BE:   loadVal = CNT_W'(BE_CYC - 1);
      default: loadVal = CNT_W'(CE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel  <= 1'b0;
      wip  <= 1'b0;
      srwd <= 1'b0;
      bp   <= 2'b00;
      cnt  <= '0;
    end else begin
      if (wip) begin
        if (cnt == '0) begin
          wip <= 1'b0;
          wel <= 1'b0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (strb.setWel) wel <= 1'b1;
      if (strb.clrWel) wel <= 1'b0;
      if (strb.wrStatus) begin
        srwd <= wrData[7];
        bp   <= wrData[3:2];
      end
      if (strb.startBusy) begin
        wip <= 1'b1;
        cnt <= loadVal;
      end
    end
  end

  assign statusReg = {srwd, 3'b000, bp, wel, wip};

  // R9
  busyStart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startBusy |=> wip);

  // R9
  welClear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> !wel);

  // R6
  statusHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrStatus |=> ($stable(srwd) && $stable(bp)));

endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
  import wpctl_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int BLK_W    = 2,
  parameter int WRSR_CYC = 16,
  parameter int PP_CYC   = 32,
  parameter int SE_CYC   = 64,
  parameter int BE_CYC   = 128,
  parameter int CE_CYC   = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        wrData,
  input  logic              wpN,
  output logic [7:0]        statusReg,
  output logic              cmdAccept,
  output logic              cmdReject
);

  wpStrobe_t  strb;
  logic       wel;
  logic       wip;
  logic       srwd;
  logic [1:0] bp;

  wpctl_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .wpN(wpN), .wel(wel), .wip(wip), .srwd(srwd),
    .bp(bp), .strb(strb), .cmdAccept(cmdAccept), .cmdReject(cmdReject)
  );

  wpctl_dp #(
    .WRSR_CYC(WRSR_CYC), .PP_CYC(PP_CYC), .SE_CYC(SE_CYC),
    .BE_CYC(BE_CYC), .CE_CYC(CE_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .wel(wel), .wip(wip), .srwd(srwd), .bp(bp), .statusReg(statusReg)
  );

endmodule

// File: tb/wp_status_ctrl_tb.sv
module wp_status_ctrl_tb_top;

  localparam int T_WRSR = 3;
  localparam int T_PP   = 5;
  localparam int T_SE   = 6;
  localparam int T_BE   = 7;
  localparam int T_CE   = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = 3'd0;
  logic [17:0] cmdAddr = '0;
  logic [7:0]  wrData = '0;
  logic        wpN = 1'b1;
  logic [7:0]  statusReg;
  logic        cmdAccept;
  logic        cmdReject;

  int total = 0;
  int bad   = 0;
  bit running = 1'b0;

  always #2 clk = ~clk;

  wp_status_ctrl #(
    .WRSR_CYC(T_WRSR), .PP_CYC(T_PP), .SE_CYC(T_SE),
    .BE_CYC(T_BE), .CE_CYC(T_CE)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .wrData(wrData), .wpN(wpN),
    .statusReg(statusReg), .cmdAccept(cmdAccept), .cmdReject(cmdReject)
  );

  // behavioural reference
  bit mWip, mWel, mSrwd, mAcc, mRej;
  bit [1:0] mBp;
  int mLeft;

  function automatic bit lockedBlk(input bit [1:0] code, input bit [1:0] b);
    case (code)
      2'd0: return 1'b0;
      2'd1: return b == 2'd3;
      2'd2: return b >= 2'd2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic int opTime(input bit [2:0] o);
    case (o)
      3'd2: return T_WRSR;
      3'd3: return T_PP;
      3'd4: return T_SE;
      3'd5: return T_BE;
      default: return T_CE;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mWip = 0; mWel = 0; mSrwd = 0; mBp = 0; mAcc = 0; mRej = 0; mLeft = 0;
    end else begin
      bit busyBefore, ok;
      busyBefore = mWip;
      ok = 0;
      if (mWip) begin
        mLeft = mLeft - 1;
        if (mLeft == 0) begin mWip = 0; mWel = 0; end
      end
      if (cmdValid && !busyBefore) begin
        case (cmdOp)
          3'd0: begin ok = 1; mWel = 1; end
          3'd1: begin ok = 1; mWel = 0; end
          3'd2: ok = mWel && !(mSrwd && !wpN);
          3'd3, 3'd4, 3'd5: ok = mWel && !lockedBlk(mBp, cmdAddr[17:16]);
          3'd6: ok = mWel && (mBp == 2'd0);
          default: ok = 0;
        endcase
        if (ok && cmdOp == 3'd2) begin mSrwd = wrData[7]; mBp = wrData[3:2]; end
        if (ok && cmdOp >= 3'd2) begin mWip = 1; mLeft = opTime(cmdOp); end
      end
      mAcc = cmdValid && ok;
      mRej = cmdValid && !ok;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check("R9 status vs model", statusReg, {mSrwd, 3'b000, mBp, mWel, mWip});
      check("R11 accept vs model", cmdAccept, mAcc);
      check("R11 reject vs model", cmdReject, mRej);
      check("R2 bits 6:4", statusReg[6:4], 0);
    end
  end

  task automatic issue(input bit [2:0] o, input bit [17:0] a, input bit [7:0] d,
                       input bit expAcc, input string tag);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = o; cmdAddr = a; wrData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    check(tag, {cmdAccept, cmdReject}, expAcc ? 2'b10 : 2'b01);
  endtask

  task automatic waitIdle();
    while (statusReg[0]) @(negedge clk);
  endtask

  initial begin
    #(4 * 20000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset status", statusReg, 8'h00);
    check("R1 reset pulses", {cmdAccept, cmdReject}, 0);
    rstN = 1'b1;
    running = 1'b1;

    issue(3'd3, 18'h00100, 8'h00, 0, "R4 program without latch");
    check("R4 status unchanged", statusReg, 8'h00);
    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    check("R3 latch set", statusReg, 8'h02);
    issue(3'd1, '0, 8'h00, 1, "R3 write disable");
    check("R3 latch clear", statusReg, 8'h00);

    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    issue(3'd2, '0, 8'hFF, 1, "R6 status write");
    check("R6 status after write", statusReg, 8'h8F);
    issue(3'd0, '0, 8'h00, 0, "R10 enable while busy");
    waitIdle();
    check("R9 latch cleared with busy", statusReg, 8'h8C);

    wpN = 1'b0;
    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    issue(3'd2, '0, 8'h00, 0, "R5 hardware lock");
    check("R5 status kept", statusReg, 8'h8E);
    wpN = 1'b1;
    issue(3'd2, '0, 8'h04, 1, "R5 lock released by pin");
    waitIdle();
    check("R6 code 01", statusReg, 8'h04);

    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    issue(3'd3, 18'h30000, 8'h00, 0, "R7 program block 3 locked");
    check("R7 latch kept", statusReg, 8'h06);
    issue(3'd6, '0, 8'h00, 0, "R8 chip erase with code 01");
    issue(3'd3, 18'h2FFFF, 8'h00, 1, "R7 program block 2 open");
    begin
      int n = 0;
      while (statusReg[0]) begin n++; @(negedge clk); end
      check("R9 program busy length", n, T_PP);
    end

    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    issue(3'd2, '0, 8'h08, 1, "R6 code 10");
    waitIdle();
    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    issue(3'd4, 18'h20010, 8'h00, 0, "R7 sector erase block 2 locked");
    issue(3'd5, 18'h1FFFF, 8'h00, 1, "R7 block erase block 1 open");
    begin
      int n = 0;
      while (statusReg[0]) begin n++; @(negedge clk); end
      check("R9 block erase busy length", n, T_BE);
    end

    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    issue(3'd2, '0, 8'h0C, 1, "R6 code 11");
    waitIdle();
    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    issue(3'd4, 18'h00000, 8'h00, 0, "R7 code 11 locks block 0");
    issue(3'd2, '0, 8'h00, 1, "R6 clear code");
    waitIdle();
    issue(3'd7, '0, 8'h00, 0, "R11 reserved op");
    issue(3'd0, '0, 8'h00, 1, "R3 write enable");
    issue(3'd6, '0, 8'h00, 1, "R8 chip erase with code 00");
    begin
      int n = 0;
      while (statusReg[0]) begin n++; @(negedge clk); end
      check("R9 chip erase busy length", n, T_CE);
    end
    check("R9 idle status", statusReg, 8'h00);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule